// File: doc/BRIEF.md
# Status Flag and Branch Decision Unit

This unit keeps the four processor status flags of a small CPU (carry, zero, sign and direction) and decides, every cycle, whether control leaves the sequential instruction path. The instruction decoder presents a control-operation code. Alongside it come the ALU's carry, zero and sign results with an update enable, the count-register value and a branch-condition select. The unit returns the flag state, a take-branch signal, a skip-next-instruction signal and the count value to write back.

Flag writes are registered and land on the next rising clock edge. The branch and skip decisions and the count write-back value are combinational, formed from the flags held at that moment and the present inputs. A branch evaluated in the same cycle as a flag update therefore sees the older flags. Explicit flag operations and ALU updates may arrive together. The explicit operation decides the flag it names, and the ALU still supplies the other flags. Data-transfer operations block all flag writes.

Top module: `flag_branch_unit`

## Requirements
- R1: While `rst` is high at a rising edge, all four flags are 0 after that edge.
- R2: Operation code 1 makes carry 0, code 2 makes carry 1, and code 3 inverts carry, each at the next edge.
- R3: Operation code 4 makes the direction flag 0 and code 11 makes it 1 at the next edge. The ALU update never changes the direction flag.
- R4: When `alu_we_i` is 1 and the operation is not a data transfer (code 6), carry, zero and sign take `alu_carry_i`, `alu_zero_i` and `alu_sign_i` at the next edge. When `alu_we_i` is 0, they hold their values unless an explicit flag operation targets them.
- R5: A data-transfer operation (code 6) leaves all four flags unchanged, even with `alu_we_i` at 1.
- R6: When a carry operation (codes 1 to 3) coincides with `alu_we_i` at 1, carry follows the carry operation while zero and sign still take the ALU values.
- R7: A conditional branch (code 7) with select 1 ("above") is taken only when carry is 0 and zero is 0.
- R8: For code 7, the other selects are 0 always, 2 zero set, 3 zero clear, 4 carry set, 5 carry clear, 6 sign set, 7 sign clear.
- R9: The loop operation (code 8) drives `count_o` with `count_i` minus 1, modulo 2^CNT_W, and asserts `take_o` exactly when that new value is nonzero. A count of 1 falls through, and a count of 0 wraps to all ones and branches.
- R10: Code 9 always asserts `skip_o`. Code 10 asserts `skip_o` only when the zero flag is 1.
- R11: `take_o` and `skip_o` use the flags held before the current edge, so a flag write shows up in decisions only from the following cycle.
- R12: All other operations (0 and 12 to 15 among them) leave `take_o` and `skip_o` at 0 and pass `count_i` unchanged to `count_o`. Codes 0 and 12 to 15 change no flag unless the ALU update is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Control-operation code |
| alu_we_i | input | 1 | ALU flag update enable |
| alu_carry_i | input | 1 | Carry from the ALU |
| alu_zero_i | input | 1 | Zero result from the ALU |
| alu_sign_i | input | 1 | Sign result from the ALU |
| count_i | input | CNT_W | Current count-register value |
| cond_i | input | 3 | Branch-condition select |
| carry_o | output | 1 | Carry flag |
| zero_o | output | 1 | Zero flag |
| sign_o | output | 1 | Sign flag |
| dir_o | output | 1 | Direction flag |
| count_o | output | CNT_W | Count value to write back |
| take_o | output | 1 | Leave the sequential path |
| skip_o | output | 1 | Skip the next instruction |

## Verification
Directed sequences first walk carry through set, invert and clear, so a stuck or swapped carry operation shows up. They then drive ALU updates under data-transfer and under arithmetic codes, which separates a missing transfer block from a missing update. Coinciding carry operations and ALU updates test the priority rule. Loop counts of 5, 1 and 0 separate testing the count before the decrement from testing it after, and expose a missing wrap. A branch issued together with a zero update checks that decisions use the old flags. A long run of mixed random codes, including unused ones, with counts biased toward small values, is then compared against a behavioural model on every cycle.

// File: rtl/fbu_pkg.sv
package fbu_pkg;
  localparam int NFLAG = 4;
  localparam int NALU  = 3;
  localparam int FL_C  = 0;
  localparam int FL_Z  = 1;
  localparam int FL_S  = 2;
  localparam int FL_D  = 3;

  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_CLR_C  = 4'd1,
    OP_SET_C  = 4'd2,
    OP_INV_C  = 4'd3,
    OP_CLR_D  = 4'd4,
    OP_ARITH  = 4'd5,
    OP_XFER   = 4'd6,
    OP_BRANCH = 4'd7,
    OP_LOOP   = 4'd8,
    OP_SKIP   = 4'd9,
    OP_SKIP_Z = 4'd10,
    OP_SET_D  = 4'd11
  } ctl_op_e;

  typedef enum logic [2:0] {
    CC_ALWAYS = 3'd0,
    CC_ABOVE  = 3'd1,
    CC_EQ     = 3'd2,
    CC_NE     = 3'd3,
    CC_C      = 3'd4,
    CC_NC     = 3'd5,
    CC_NEG    = 3'd6,
    CC_POS    = 3'd7
  } cond_e;
endpackage

// File: rtl/fbu_flag_reg.sv
module fbu_flag_reg
  import fbu_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [3:0]          op,
  input  logic                alu_we,
  input  logic [NALU-1:0]     alu_flags,
  output logic [NFLAG-1:0]    flags
);
  logic [NFLAG-1:0] ctl_hit;
  logic [NFLAG-1:0] ctl_val;
  logic             alu_en;

  always_comb begin
    ctl_hit = '0;
    ctl_val = '0;
    case (op)
      OP_CLR_C: begin ctl_hit[FL_C] = 1'b1; ctl_val[FL_C] = 1'b0;         end
      OP_SET_C: begin ctl_hit[FL_C] = 1'b1; ctl_val[FL_C] = 1'b1;         end
      OP_INV_C: begin ctl_hit[FL_C] = 1'b1; ctl_val[FL_C] = ~flags[FL_C]; end
      OP_CLR_D: begin ctl_hit[FL_D] = 1'b1; ctl_val[FL_D] = 1'b0;         end
      OP_SET_D: begin ctl_hit[FL_D] = 1'b1; ctl_val[FL_D] = 1'b1;         end
      default:  ;
    endcase
  end

  assign alu_en = alu_we && (op != OP_XFER);

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    if (i < NALU) begin : g_alu_fed
      always_ff @(posedge clk) begin
        if (rst)             flags[i] <= 1'b0;
        else if (ctl_hit[i]) flags[i] <= ctl_val[i];
        else if (alu_en)     flags[i] <= alu_flags[i];
      end
    end else begin : g_ctl_only
      always_ff @(posedge clk) begin
        if (rst)             flags[i] <= 1'b0;
        else if (ctl_hit[i]) flags[i] <= ctl_val[i];
      end
    end
  end
endmodule

// File: rtl/fbu_loop_count.sv
module fbu_loop_count #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] count_in,
  input  logic             is_loop,
  output logic [CNT_W-1:0] count_out,
  output logic             after_nz
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  logic [CNT_W-1:0] dec;

  assign dec       = count_in - ONE;
  assign count_out = is_loop ? dec : count_in;
  assign after_nz  = |dec;
endmodule

// File: rtl/fbu_cond_eval.sv
module fbu_cond_eval
  import fbu_pkg::*;
(
  input  logic [3:0]       op,
  input  logic [2:0]       cond,
  input  logic [NFLAG-1:0] flags,
  input  logic             loop_nz,
  output logic             take,
  output logic             skip
);
  logic cc_true;

  always_comb begin
    case (cond)
      CC_ALWAYS: cc_true = 1'b1;
      CC_ABOVE:  cc_true = ~flags[FL_C] & ~flags[FL_Z];
      CC_EQ:     cc_true =  flags[FL_Z];
      CC_NE:     cc_true = ~flags[FL_Z];
      CC_C:      cc_true =  flags[FL_C];
      CC_NC:     cc_true = ~flags[FL_C];
      CC_NEG:    cc_true =  flags[FL_S];
      default:   cc_true = ~flags[FL_S];
    endcase
  end

  always_comb begin
    take = 1'b0;
    skip = 1'b0;
    case (op)
      OP_BRANCH: take = cc_true;
      OP_LOOP:   take = loop_nz;
      OP_SKIP:   skip = 1'b1;
      OP_SKIP_Z: skip = flags[FL_Z];
      default:   ;
    endcase
  end
endmodule

// File: rtl/flag_branch_unit.sv
module flag_branch_unit
  import fbu_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       op_i,
  input  logic             alu_we_i,
  input  logic             alu_carry_i,
  input  logic             alu_zero_i,
  input  logic             alu_sign_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [2:0]       cond_i,
  output logic             carry_o,
  output logic             zero_o,
  output logic             sign_o,
  output logic             dir_o,
  output logic [CNT_W-1:0] count_o,
  output logic             take_o,
  output logic             skip_o
);
  logic [NFLAG-1:0] flags;
  logic [NALU-1:0]  alu_flags;
  logic             loop_nz;

  always_comb begin
    alu_flags       = '0;
    alu_flags[FL_C] = alu_carry_i;
    alu_flags[FL_Z] = alu_zero_i;
    alu_flags[FL_S] = alu_sign_i;
  end

  fbu_flag_reg u_flags (
    .clk       (clk),
    .rst       (rst),
    .op        (op_i),
    .alu_we    (alu_we_i),
    .alu_flags (alu_flags),
    .flags     (flags)
  );

  fbu_loop_count #(.CNT_W(CNT_W)) u_loop (
    .count_in  (count_i),
    .is_loop   (op_i == OP_LOOP),
    .count_out (count_o),
    .after_nz  (loop_nz)
  );

  fbu_cond_eval u_cond (
    .op      (op_i),
    .cond    (cond_i),
    .flags   (flags),
    .loop_nz (loop_nz),
    .take    (take_o),
    .skip    (skip_o)
  );

  assign carry_o = flags[FL_C];
  assign zero_o  = flags[FL_Z];
  assign sign_o  = flags[FL_S];
  assign dir_o   = flags[FL_D];
endmodule

// File: rtl/fbu_checker.sv
module fbu_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       op_i,
  input logic             alu_we_i,
  input logic             alu_carry_i,
  input logic             alu_zero_i,
  input logic             alu_sign_i,
  input logic [CNT_W-1:0] count_i,
  input logic [2:0]       cond_i,
  input logic             carry_o,
  input logic             zero_o,
  input logic             sign_o,
  input logic             dir_o,
  input logic [CNT_W-1:0] count_o,
  input logic             take_o,
  input logic             skip_o
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!carry_o && !zero_o && !sign_o && !dir_o));

  assert_set_carry_R2: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd2) |=> carry_o);

  assert_inv_carry_R2: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd3) |=> (carry_o != $past(carry_o)));

  assert_clr_dir_R3: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd4) |=> !dir_o);

  assert_alu_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (alu_we_i && op_i == 4'd5) |=> (zero_o == $past(alu_zero_i)));

  assert_xfer_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd6) |=> ($stable(carry_o) && $stable(zero_o) && $stable(sign_o) && $stable(dir_o)));

  assert_clr_wins_R6: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd1 && alu_we_i) |=> (!carry_o && zero_o == $past(alu_zero_i)));

  assert_above_R7: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd7 && cond_i == 3'd1) |-> (take_o == (!carry_o && !zero_o)));

  assert_loop_R9: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd8) |-> (count_o == count_i - 1'b1 && take_o == (count_i != 1)));

  assert_skip_R10: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd9) |-> skip_o);

  assert_idle_R12: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd0) |-> (!take_o && !skip_o && count_o == count_i));
endmodule

bind flag_branch_unit fbu_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .op_i(op_i), .alu_we_i(alu_we_i),
  .alu_carry_i(alu_carry_i), .alu_zero_i(alu_zero_i), .alu_sign_i(alu_sign_i),
  .count_i(count_i), .cond_i(cond_i), .carry_o(carry_o), .zero_o(zero_o),
  .sign_o(sign_o), .dir_o(dir_o), .count_o(count_o), .take_o(take_o),
  .skip_o(skip_o)
);

// File: tb/tb_flag_branch_unit.sv
module tb_flag_branch_unit;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;
  localparam int MASK = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    op_i = '0;
  logic          alu_we_i = 1'b0;
  logic          alu_carry_i = 1'b0;
  logic          alu_zero_i = 1'b0;
  logic          alu_sign_i = 1'b0;
  logic [CW-1:0] count_i = '0;
  logic [2:0]    cond_i = '0;
  logic          carry_o, zero_o, sign_o, dir_o, take_o, skip_o;
  logic [CW-1:0] count_o;

  int vectors = 0;
  int fails = 0;
  bit done = 0;
  int m_c = 0, m_z = 0, m_s = 0, m_d = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flag_branch_unit #(.CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .op_i(op_i), .alu_we_i(alu_we_i),
    .alu_carry_i(alu_carry_i), .alu_zero_i(alu_zero_i), .alu_sign_i(alu_sign_i),
    .count_i(count_i), .cond_i(cond_i), .carry_o(carry_o), .zero_o(zero_o),
    .sign_o(sign_o), .dir_o(dir_o), .count_o(count_o), .take_o(take_o),
    .skip_o(skip_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int op);
    case (op)
      1, 2, 3:  return "R2";
      4, 11:    return "R3";
      5:        return "R4";
      6:        return "R5";
      7:        return "R8";
      8:        return "R9";
      9, 10:    return "R10";
      default:  return "R12";
    endcase
  endfunction

  function automatic int cond_true(input int cc);
    case (cc)
      0: return 1;
      1: return (m_c == 0 && m_z == 0) ? 1 : 0;
      2: return m_z;
      3: return 1 - m_z;
      4: return m_c;
      5: return 1 - m_c;
      6: return m_s;
      default: return 1 - m_s;
    endcase
  endfunction

  task automatic step(input int op, input bit upd, input bit ac, input bit az,
                      input bit a_s, input int cnt, input int cc, input string req);
    int e_take, e_skip, e_cnt, n_c, n_z, n_s, n_d;
    @(negedge clk);
    op_i = op[3:0]; alu_we_i = upd; alu_carry_i = ac; alu_zero_i = az;
    alu_sign_i = a_s; count_i = cnt[CW-1:0]; cond_i = cc[2:0];
    #1;
    e_take = 0; e_skip = 0; e_cnt = cnt & MASK;
    if (op == 7) e_take = cond_true(cc);
    if (op == 8) begin
      e_cnt = (cnt - 1) & MASK;
      e_take = (e_cnt != 0) ? 1 : 0;
    end
    if (op == 9) e_skip = 1;
    if (op == 10) e_skip = m_z;
    check(req, "carry", int'(carry_o), m_c);
    check(req, "zero", int'(zero_o), m_z);
    check(req, "sign", int'(sign_o), m_s);
    check(req, "dir", int'(dir_o), m_d);
    check(req, "take", int'(take_o), e_take);
    check(req, "skip", int'(skip_o), e_skip);
    check(req, "count", int'(count_o), e_cnt);
    n_c = m_c; n_z = m_z; n_s = m_s; n_d = m_d;
    if (upd && op != 6) begin n_c = ac; n_z = az; n_s = a_s; end
    if (op == 1) n_c = 0;
    if (op == 2) n_c = 1;
    if (op == 3) n_c = 1 - m_c;
    if (op == 4) n_d = 0;
    if (op == 11) n_d = 1;
    @(posedge clk);
    m_c = n_c; m_z = n_z; m_s = n_s; m_d = n_d;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1", "carry", int'(carry_o), 0);
    check("R1", "zero", int'(zero_o), 0);
    check("R1", "sign", int'(sign_o), 0);
    check("R1", "dir", int'(dir_o), 0);
    rst = 1'b0;
    // R2: carry control sequence
    step(2, 0, 0, 0, 0, 0, 0, "R2");
    step(3, 0, 0, 0, 0, 0, 0, "R2");
    step(3, 0, 0, 0, 0, 0, 0, "R2");
    step(1, 0, 0, 0, 0, 0, 0, "R2");
    // R3: direction set then clear, ALU may not touch it
    step(11, 1, 1, 1, 1, 0, 0, "R3");
    step(4, 0, 0, 0, 0, 0, 0, "R3");
    // R4: ALU update and its absence
    step(5, 1, 1, 1, 1, 0, 0, "R4");
    step(5, 0, 0, 0, 0, 0, 0, "R4");
    // R5: transfer blocks update
    step(6, 1, 0, 0, 0, 0, 0, "R5");
    step(0, 0, 0, 0, 0, 0, 0, "R5");
    // R6: carry op beats ALU carry, other flags follow ALU
    step(1, 1, 1, 0, 0, 0, 0, "R6");
    step(2, 1, 0, 1, 1, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 0, 0, "R6");
    // R7: above with each flag combination
    step(5, 1, 0, 0, 0, 0, 0, "R7");
    step(7, 0, 0, 0, 0, 0, 1, "R7");
    step(5, 1, 1, 0, 0, 0, 0, "R7");
    step(7, 0, 0, 0, 0, 0, 1, "R7");
    step(5, 1, 0, 1, 0, 0, 0, "R7");
    step(7, 0, 0, 0, 0, 0, 1, "R7");
    // R8: every select
    for (int k = 0; k < 8; k++) step(7, 0, 0, 0, 0, 0, k, "R8");
    // R9: loop counts
    step(8, 0, 0, 0, 0, 5, 0, "R9");
    step(8, 0, 0, 0, 0, 1, 0, "R9");
    step(8, 0, 0, 0, 0, 0, 0, "R9");
    // R10: skips with zero clear and set
    step(9, 1, 0, 0, 0, 0, 0, "R10");
    step(10, 0, 0, 0, 0, 0, 0, "R10");
    step(5, 1, 0, 1, 0, 0, 0, "R10");
    step(10, 0, 0, 0, 0, 0, 0, "R10");
    // R11: branch issued with a zero update sees old flag
    step(5, 1, 0, 0, 0, 0, 0, "R11");
    step(7, 1, 0, 1, 0, 0, 2, "R11");
    step(7, 0, 0, 0, 0, 0, 2, "R11");
    // R12: idle and unused codes
    step(0, 0, 0, 0, 0, 7, 3, "R12");
    step(13, 0, 0, 0, 0, 9, 0, "R12");
    step(15, 1, 1, 0, 1, 3, 0, "R12");
    for (int n = 0; n < 2000; n++) begin
      int op, cnt;
      op = int'($urandom % 16);
      cnt = ($urandom % 4 == 0) ? int'($urandom % 3) : int'($urandom & MASK);
      step(op, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           cnt, int'($urandom % 8), tag_of(op));
    end
    finish_run();
  end
endmodule